// File: doc/BRIEF.md
# Burst Address Sequencer

The block generates the address for each beat of a four-beat burst. When either of two address strobes is accepted it captures the full incoming address. The upper bits are held unchanged for the rest of the burst. The low two bits become the start of a beat sequence.

On each clock edge where the step input is high, the sequence moves on by one beat. While the step input is low, the sequence holds its place, which suspends the burst. A static order input picks one of two orders around the captured start:
- **Interleaved:** the beat index is XORed into the start bits.
- **Linear:** the beat index is added to the start bits, modulo four.

After four beats the sequence arrives back at its start address. Read and write bursts use the same sequencer. The output is driven from registers through a small combinational map, so it settles in the cycle after the edge that loads or steps it.

Top module: `burst_seq`

## Requirements
- R1: A clock edge with `strobe_cpu` or `strobe_ctl` high (either one or both) loads `addr_in[1:0]` as the burst start and clears the beat index. After that edge, `burst_addr[1:0]` equals the loaded start.
- R2: `burst_addr[AW-1:2]` takes the value of `addr_in[AW-1:2]` at a loading edge and keeps that value on every edge without a load.
- R3: A clock edge with `step_en` high and no strobe advances the beat index by one.
- R4: A clock edge with no strobe and `step_en` low leaves `burst_addr` unchanged.
- R5: With `order_sel` = 1 (interleaved), `burst_addr[1:0]` = start XOR beat index. For example, start 01 gives the beats 01, 00, 11, 10.
- R6: With `order_sel` = 0 (linear), `burst_addr[1:0]` = (start + beat index) mod 4. For example, start 10 gives the beats 10, 11, 00, 01.
- R7: After four steps, `burst_addr[1:0]` is back at the start of the burst, in both orders.
- R8: When a strobe and `step_en` are both high on the same edge, the load wins. The output then shows the new start, with a beat index of zero.
- R9: A clock edge with `rst` high clears the start, the beat index and the upper bits, so `burst_addr` reads all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_cpu | input | 1 | First address strobe, active high |
| strobe_ctl | input | 1 | Second address strobe, active high |
| step_en | input | 1 | Advance the burst by one beat, active high |
| order_sel | input | 1 | Static order select: 1 = interleaved, 0 = linear |
| addr_in | input | AW | Incoming address, captured on a strobe |
| burst_addr | output | AW | Current beat address |

## Verification
A load and a step can land on the same edge. The load must win and reset the beat index, so the next output is the new start and not the old sequence advanced by one beat. The bench provokes this directly, using both strobes and both orders. It also provokes it randomly, with loads and steps drawn independently on every cycle. The bench judges the result against a model that applies the load before the step.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    localparam int unsigned BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORDER_LINEAR = 1'b0,
        ORDER_XOR    = 1'b1
    } order_e;
endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
    import burst_seq_pkg::*;
#(
    parameter int unsigned AW = 18,
    localparam int unsigned UW = AW - BEAT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [AW-1:0] addr_in,
    output beat_t         start_q,
    output beat_t         beat_q,
    output logic [UW-1:0] upper_q
);
    typedef struct packed {
        beat_t         start;
        beat_t         beat;
        logic [UW-1:0] upper;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.start = addr_in[BEAT_W-1:0];
            st_d.upper = addr_in[AW-1:BEAT_W];
            st_d.beat  = '0;
        end else if (step) begin
            st_d.beat  = st_q.beat + beat_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign start_q = st_q.start;
    assign beat_q  = st_q.beat;
    assign upper_q = st_q.upper;
endmodule

// File: rtl/burst_seq_map.sv
module burst_seq_map
    import burst_seq_pkg::*;
(
    input  beat_t  start,
    input  beat_t  beat,
    input  order_e order,
    output beat_t  low
);
    beat_t xor_low;
    beat_t lin_low;

    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
        assign xor_low[b] = start[b] ^ beat[b];
    end

    assign lin_low = start + beat;

    always_comb begin
        low = (order == ORDER_XOR) ? xor_low : lin_low;
    end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
    import burst_seq_pkg::*;
#(
    parameter int unsigned AW = 18
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          strobe_cpu,
    input  logic          strobe_ctl,
    input  logic          step_en,
    input  logic          order_sel,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] burst_addr
);
    localparam int unsigned UW = AW - BEAT_W;

    logic          load;
    beat_t         start_q;
    beat_t         beat_q;
    beat_t         low;
    logic [UW-1:0] upper_q;
    order_e        order;

    assign load  = strobe_cpu | strobe_ctl;
    assign order = order_e'(order_sel);

    burst_seq_ctrl #(.AW(AW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .step    (step_en),
        .addr_in (addr_in),
        .start_q (start_q),
        .beat_q  (beat_q),
        .upper_q (upper_q)
    );

    burst_seq_map u_map (
        .start (start_q),
        .beat  (beat_q),
        .order (order),
        .low   (low)
    );

    assign burst_addr = {upper_q, low};
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
    parameter int unsigned AW = 18
) (
    input logic          clk,
    input logic          rst,
    input logic          strobe_cpu,
    input logic          strobe_ctl,
    input logic          step_en,
    input logic          order_sel,
    input logic [AW-1:0] addr_in,
    input logic [AW-1:0] burst_addr
);
    logic ld;
    assign ld = strobe_cpu | strobe_ctl;

    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> burst_addr == '0);

    a_r1_load_start: assert property (@(posedge clk) disable iff (rst)
        ld |=> burst_addr[1:0] == $past(addr_in[1:0]));

    a_r2_upper_load: assert property (@(posedge clk) disable iff (rst)
        ld |=> burst_addr[AW-1:2] == $past(addr_in[AW-1:2]));

    a_r2_upper_keep: assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(burst_addr[AW-1:2]));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!ld && !step_en) |=> ($past(order_sel) != order_sel) || $stable(burst_addr));

    a_r6_linear_step: assert property (@(posedge clk) disable iff (rst)
        (!ld && step_en && !order_sel) |=>
            order_sel || burst_addr[1:0] == 2'($past(burst_addr[1:0]) + 2'd1));

    a_r5_xor_step: assert property (@(posedge clk) disable iff (rst)
        (!ld && step_en && order_sel) |=>
            !order_sel || $countones(burst_addr[1:0] ^ $past(burst_addr[1:0])) != 0);
endmodule

bind burst_seq burst_seq_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .strobe_cpu (strobe_cpu),
    .strobe_ctl (strobe_ctl),
    .step_en    (step_en),
    .order_sel  (order_sel),
    .addr_in    (addr_in),
    .burst_addr (burst_addr)
);

// File: tb/burst_seq_test.sv
`timescale 1ns/1ps
module burst_seq_test;
    localparam int AW = 18;

    logic          clk = 1'b0;
    logic          rst;
    logic          strobe_cpu, strobe_ctl, step_en, order_sel;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] burst_addr;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [1:0]    m_start, m_beat;
    logic [AW-3:0] m_upper;

    always #2 clk = ~clk;

    burst_seq #(.AW(AW)) uut (
        .clk(clk), .rst(rst), .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl),
        .step_en(step_en), .order_sel(order_sel), .addr_in(addr_in),
        .burst_addr(burst_addr)
    );

    function automatic logic [AW-1:0] exp_addr();
        logic [1:0] lo;
        lo = order_sel ? (m_start ^ m_beat) : 2'(m_start + m_beat);
        return {m_upper, lo};
    endfunction

    task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, update model at posedge, check at next negedge
    task automatic cyc(logic r, logic sc, logic sk, logic st, logic [AW-1:0] a, string req);
        rst = r; strobe_cpu = sc; strobe_ctl = sk; step_en = st; addr_in = a;
        @(posedge clk);
        if (r) begin m_start = 0; m_beat = 0; m_upper = 0; end
        else if (sc || sk) begin m_start = a[1:0]; m_upper = a[AW-1:2]; m_beat = 0; end
        else if (st) m_beat = m_beat + 2'd1;
        @(negedge clk);
        chk(req, burst_addr, exp_addr());
    endtask

    initial begin
        #400000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] a;
        void'($urandom(32'd1357));
        order_sel = 1'b1;
        @(negedge clk);
        cyc(1, 0, 0, 0, '0, "R9");
        cyc(1, 1, 0, 1, 18'h3ffff, "R9");
        chk("R9 literal", burst_addr, '0);

        // interleaved: all starts, full burst with wrap (R5, R7)
        for (int s = 0; s < 4; s++) begin
            a = {16'(s * 37 + 5), 2'(s)};
            cyc(0, s[0], ~s[0], 0, a, "R1");
            for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, '0, "R5");
            chk("R7 xor wrap", burst_addr, a);
        end
        cyc(0, 1, 0, 0, {16'h0abc, 2'b01}, "R1");
        cyc(0, 0, 0, 1, '0, "R5");
        chk("R5 literal 01->00", burst_addr, {16'h0abc, 2'b00});
        cyc(0, 0, 0, 1, '0, "R5");
        chk("R5 literal 00->11", burst_addr, {16'h0abc, 2'b11});

        // linear
        order_sel = 1'b0;
        cyc(0, 0, 1, 0, {16'h1234, 2'b10}, "R1");
        cyc(0, 0, 0, 1, '0, "R6");
        chk("R6 literal 10->11", burst_addr, {16'h1234, 2'b11});
        cyc(0, 0, 0, 1, '0, "R6");
        chk("R6 literal 11->00", burst_addr, {16'h1234, 2'b00});
        cyc(0, 0, 0, 0, 18'h2aaaa, "R4");
        chk("R4 hold", burst_addr, {16'h1234, 2'b00});
        cyc(0, 0, 0, 1, 18'h15555, "R2");
        chk("R2 upper kept", burst_addr, {16'h1234, 2'b01});
        cyc(0, 0, 0, 1, '0, "R7");
        chk("R7 linear wrap", burst_addr, {16'h1234, 2'b10});

        // load and step together: load wins (R8)
        cyc(0, 0, 0, 1, '0, "R3");
        cyc(0, 1, 1, 1, {16'h00ff, 2'b11}, "R8");
        chk("R8 load beats step", burst_addr, {16'h00ff, 2'b11});
        order_sel = 1'b1;
        cyc(0, 0, 0, 1, '0, "R3");
        cyc(0, 0, 1, 1, {16'h0f0f, 2'b10}, "R8");
        chk("R8 load beats step xor", burst_addr, {16'h0f0f, 2'b10});

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic sc, sk;
            if (i % 97 == 0) order_sel = ~order_sel;
            sc = ($urandom % 5) == 0;
            sk = ($urandom % 5) == 0;
            cyc(($urandom % 150) == 0, sc, sk, $urandom % 2, 18'($urandom), "R3 random");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule